// File: doc/BRIEF.md
# Linear Page-Table Address Translator

This block turns a virtual address into a physical address by walking a single-level linear page table kept in main memory. A requester presents a virtual address. The block splits it into a virtual page number (VPN) and a byte offset, then forms the address of the page-table entry (PTE) as the table base plus the VPN times four. It reads that 32-bit entry over a simple memory read port and returns either a physical address or a fault.

The block keeps no table storage of its own. Each translation costs exactly one memory read. The frame number taken from the entry replaces the VPN, and the offset passes through untouched. Only one translation is in flight at any time.

The control is a four-state machine:
- `ST_IDLE` accepts a request and moves to `ST_ISSUE`.
- `ST_ISSUE` presents the PTE read and moves to `ST_WAIT` once the memory takes it.
- `ST_WAIT` waits for read data and moves to `ST_DONE` when the data arrives.
- `ST_DONE` holds the result and moves back to `ST_IDLE` once the consumer takes it.

Top module: `pt_linear_xlate`

## Requirements
- R1: The VPN is the top `VA_W-OFF_W` bits of the virtual address and the offset is the low `OFF_W = log2(PAGE_BYTES)` bits. With the defaults this is a 2-bit VPN in bits 5:4 and a 4-bit offset in bits 3:0. `rsp_vpn` reports the VPN of the accepted request.
- R2: The PTE read address is `pt_base + VPN*4`, modulo 2^MEM_AW. `pt_base` is sampled in the cycle the request is accepted, and changing it afterwards has no effect on that translation.
- R3: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is seen. Exactly one read is issued per translation.
- R4: `req_ready` is high only when no translation is in flight. A request offered during a translation is not accepted.
- R5: When bit 31 of the PTE is 1, the result is `rsp_fault=0` and `rsp_paddr = {PTE[PFN_W-1:0], offset}`, where `PFN_W = PA_W-OFF_W`.
- R6: When bit 31 of the PTE is 0, the result is `rsp_fault=1` and `rsp_paddr=0`, and `rsp_vpn` holds the faulting VPN.
- R7: PTE bits 30 down to `PFN_W` have no effect on the result.
- R8: The response is held stable with `rsp_valid` high until `rsp_ready`. One cycle after `rsp_ready`, `rsp_valid` is low and `req_ready` is high.
- R9: After reset, `req_ready=1`, `mem_rd_valid=0` and `rsp_valid=0`.
- R10: With the table mapping page 0 to frame 3, page 1 to frame 7, page 2 to frame 5 and page 3 to frame 2, virtual address 21 translates to physical address 117.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | MEM_AW | Page-table base address, sampled on request accept |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| mem_rd_valid | output | 1 | PTE read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | MEM_AW | Byte address of the PTE |
| mem_rsp_valid | input | 1 | PTE read data valid |
| mem_rsp_data | input | 32 | PTE contents |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Entry not valid |
| rsp_paddr | output | PA_W | Physical address, zero on fault |
| rsp_vpn | output | VPN_W | VPN of the translation |

## Verification
On every cycle the assertions check several properties:
- the read and response hold rules;
- the exclusivity of request-ready, read-valid and response-valid;
- the zero address on a fault;
- that the physical offset equals the offset captured at accept.

Only the bench's sweeps can show that the fetched frame number lands in the right bits and that the PTE address comes from the sampled base rather than the live one. The sweeps cover all 64 virtual addresses under two tables and two bases. They also show that the junk bits of a PTE are ignored and that requests offered mid-flight are refused.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } xlate_state_e;

    localparam int PTE_W       = 32;
    localparam int PTE_BYTES   = 4;
    localparam int PTE_SHIFT   = $clog2(PTE_BYTES);
    localparam int PTE_VLD_BIT = 31;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
    parameter int VA_W   = 6,
    parameter int OFF_W  = 4,
    parameter int MEM_AW = 16,
    localparam int VPN_W = VA_W - OFF_W
) (
    input  logic [VA_W-1:0]   vaddr,
    input  logic [MEM_AW-1:0] base,
    output logic [VPN_W-1:0]  vpn,
    output logic [OFF_W-1:0]  off,
    output logic [MEM_AW-1:0] pte_addr
);
    import pt_xlate_pkg::*;

    always_comb begin
        vpn      = vaddr[VA_W-1:OFF_W];
        off      = vaddr[OFF_W-1:0];
        pte_addr = base + (MEM_AW'(vpn) << PTE_SHIFT);
    end
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode #(
    parameter int PFN_W = 3
) (
    input  logic [pt_xlate_pkg::PTE_W-1:0] pte,
    output logic                           present,
    output logic [PFN_W-1:0]               pfn
);
    import pt_xlate_pkg::*;

    logic unused_mid;

    always_comb begin
        present    = pte[PTE_VLD_BIT];
        pfn        = pte[PFN_W-1:0];
        unused_mid = ^pte[PTE_VLD_BIT-1:PFN_W];
    end
endmodule

// File: rtl/pt_linear_xlate.sv
module pt_linear_xlate #(
    parameter int VA_W       = 6,
    parameter int PA_W       = 7,
    parameter int PAGE_BYTES = 16,
    parameter int MEM_AW     = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int VPN_W     = VA_W - OFF_W,
    localparam int PFN_W     = PA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] pt_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [VPN_W-1:0]  rsp_vpn
);
    import pt_xlate_pkg::*;

    xlate_state_e state_q, state_d;

    logic [VPN_W-1:0]  s_vpn;
    logic [OFF_W-1:0]  s_off;
    logic [MEM_AW-1:0] s_pte_addr;
    logic              d_present;
    logic [PFN_W-1:0]  d_pfn;

    logic [VPN_W-1:0]  vpn_q;
    logic [OFF_W-1:0]  off_q;
    logic [MEM_AW-1:0] pte_addr_q;
    logic [PA_W-1:0]   paddr_q;
    logic              fault_q;

    logic accept, rd_fire, rsp_take, data_in;

    pt_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW)) u_split (
        .vaddr    (req_vaddr),
        .base     (pt_base),
        .vpn      (s_vpn),
        .off      (s_off),
        .pte_addr (s_pte_addr)
    );

    pt_pte_decode #(.PFN_W(PFN_W)) u_decode (
        .pte     (mem_rsp_data),
        .present (d_present),
        .pfn     (d_pfn)
    );

    assign accept   = (state_q == ST_IDLE)  && req_valid;
    assign rd_fire  = (state_q == ST_ISSUE) && mem_rd_ready;
    assign data_in  = (state_q == ST_WAIT)  && mem_rsp_valid;
    assign rsp_take = (state_q == ST_DONE)  && rsp_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_rd_ready)  state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:  if (rsp_ready)     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        rsp_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready    = 1'b1;
            ST_ISSUE: mem_rd_valid = 1'b1;
            ST_WAIT:  ;
            ST_DONE:  rsp_valid    = 1'b1;
            default:  ;
        endcase
        mem_rd_addr = pte_addr_q;
        rsp_fault   = fault_q;
        rsp_paddr   = paddr_q;
        rsp_vpn     = vpn_q;
    end

    // Datapath capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q      <= '0;
            off_q      <= '0;
            pte_addr_q <= '0;
            paddr_q    <= '0;
            fault_q    <= 1'b0;
        end else begin
            if (accept) begin
                vpn_q      <= s_vpn;
                off_q      <= s_off;
                pte_addr_q <= s_pte_addr;
            end
            if (data_in) begin
                fault_q <= !d_present;
                paddr_q <= d_present ? {d_pfn, off_q} : '0;
            end
        end
    end

    logic unused_evt;
    assign unused_evt = rd_fire ^ rsp_take;
endmodule

// File: rtl/pt_linear_xlate_chk.sv
module pt_linear_xlate_chk #(
    parameter int VA_W   = 6,
    parameter int PA_W   = 7,
    parameter int OFF_W  = 4,
    parameter int MEM_AW = 16,
    parameter int VPN_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [MEM_AW-1:0] mem_rd_addr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [VPN_W-1:0]  rsp_vpn
);
    logic [VA_W-1:0] seen_va;

    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_va <= '0;
        else if (req_valid && req_ready) seen_va <= req_vaddr;
    end

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_rd_valid, rsp_valid}));

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0);

    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_fault) && $stable(rsp_vpn));

    p_rsp_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> !rsp_valid && req_ready);

    p_offset_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == seen_va[OFF_W-1:0]);

    p_vpn_report_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_vpn == seen_va[VA_W-1:OFF_W]);
endmodule

bind pt_linear_xlate pt_linear_xlate_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .MEM_AW(MEM_AW), .VPN_W(VPN_W)
) u_chk (.*);

// File: tb/sim_pt_linear_xlate.sv
module sim_pt_linear_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pt_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [15:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [6:0]  rsp_paddr;
    logic [1:0]  rsp_vpn;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ptab [4];
    logic [15:0] base;

    always #4 clk = ~clk;

    pt_linear_xlate u0 (.*);

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic xlate(input logic [5:0] va, input int lat);
        logic [1:0]  vpn = va[5:4];
        logic [3:0]  off = va[3:0];
        logic [15:0] exp_addr = base + 16'(vpn) * 16'd4;
        logic        ok_ent = ptab[vpn][31];
        logic [6:0]  exp_pa = ok_ent ? {ptab[vpn][2:0], off} : 7'd0;
        logic [6:0]  pa_seen;
        @(negedge clk);
        pt_base = base; req_vaddr = va; req_valid = 1'b1;
        check(req_ready == 1'b1, "R4 idle ready", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        pt_base = base ^ 16'h5A50;
        check(mem_rd_valid == 1'b1, "R3 read issued", 32'(mem_rd_valid), 1);
        check(mem_rd_addr == exp_addr, "R2 pte address", 32'(mem_rd_addr), 32'(exp_addr));
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(mem_rd_valid && mem_rd_addr == exp_addr, "R3 read held",
                  32'(mem_rd_addr), 32'(exp_addr));
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        check(mem_rd_valid == 1'b0, "R3 single read", 32'(mem_rd_valid), 0);
        req_valid = 1'b1; req_vaddr = ~va;
        for (int i = 0; i <= lat; i++) begin
            check(req_ready == 1'b0, "R4 busy refuse", 32'(req_ready), 0);
            @(negedge clk);
        end
        check(rsp_valid == 1'b0 && mem_rd_valid == 1'b0, "R4 no second accept",
              32'(rsp_valid), 0);
        req_valid = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = ptab[vpn];
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'hFFFF_FFFF;
        check(rsp_valid == 1'b1, "R8 result valid", 32'(rsp_valid), 1);
        check(rsp_vpn == vpn, "R1 vpn field", 32'(rsp_vpn), 32'(vpn));
        if (ok_ent) begin
            check(rsp_fault == 1'b0 && rsp_paddr == exp_pa, "R5 R7 paddr",
                  32'(rsp_paddr), 32'(exp_pa));
        end else begin
            check(rsp_fault == 1'b1 && rsp_paddr == 7'd0, "R6 fault",
                  {rsp_fault, 24'd0, rsp_paddr}, {1'b1, 31'd0});
        end
        pa_seen = rsp_paddr;
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == pa_seen, "R8 result held",
                  32'(rsp_paddr), 32'(pa_seen));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R8 release", {rsp_valid, req_ready}, 32'b01);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && !mem_rd_valid && !rsp_valid, "R9 reset state",
              {req_ready, mem_rd_valid, rsp_valid}, 32'b100);
        rst_n = 1'b1;

        // Table A: mapping 3,7,5,2 with junk middle bits
        ptab[0] = 32'h8000_0000 | (32'h0ACE_5A5 << 3) | 32'd3;
        ptab[1] = 32'h8000_0000 | (32'h0F0F_0F0 << 3) | 32'd7;
        ptab[2] = 32'h8000_0000 | (32'h0123_456 << 3) | 32'd5;
        ptab[3] = 32'h8000_0000 | (32'h0FFF_FFF << 3) | 32'd2;
        base = 16'h0100;
        xlate(6'd21, 1);
        check(rsp_paddr == 7'd117, "R10 example va 21", 32'(rsp_paddr), 117);
        for (int v = 0; v < 64; v++) xlate(6'(v), v % 3);

        // Table B: pages 1 and 3 invalid, other base that wraps
        ptab[1] = 32'h7FFF_FFFF;
        ptab[3] = 32'h0000_0006;
        ptab[0] = 32'h8000_0006;
        base = 16'hFFF8;
        for (int v = 0; v < 64; v++) xlate(6'(v), (v + 1) % 3);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule